// File: doc/BRIEF.md
# Flash Host-Interface Power-State Controller

This block follows the power state of a parallel flash memory's host interface. It watches chip enable, output enable, the address bus and the busy flag of the embedded program/erase engine. It also watches two digital supply flags: supply below the lock-out level, and supply below the reset level. From these it selects one of five interface states and drives the signals that depend on that state: output-drive enable, data-latch hold, program/erase inhibit, a one-clock cold-reset request to the embedded engine, and a combined low-power indicator. All timing thresholds are parameters counted in clock cycles.

While the device is selected and the address does not change, the interface drops into automatic sleep after `SLEEP_CYC` cycles. In sleep the last read data stays latched. After a further `STBY_CYC` cycles in sleep the interface reports standby, even though chip enable is still low. Any address change, or a new falling edge of chip enable, starts a fresh access. The combined low-power indicator is set only when the interface is in standby and the embedded engine is idle.

Top module: `flash_if_pwr_ctrl`

## Requirements
- R1: With chip enable high (and no supply event), the state becomes standby on the next clock. Output drive is off, and address and output-enable changes have no effect on any output.
- R2: `ready_o` equals the inverse of `eng_busy_i` in every state, with no clock delay.
- R3: In active, once the address has stayed unchanged for `SLEEP_CYC` consecutive clocks, the state becomes automatic sleep.
- R4: In sleep, `data_hold_o` is 1 and `drive_en_o` follows output enable (1 when `oe_ni` is low). Toggling `oe_ni` does not move the sleep-to-standby timeout.
- R5: An address change while selected, in sleep or in timed-out standby, returns the state to active on the next clock. It also restarts the stability count from zero.
- R6: After `STBY_CYC` clocks in sleep with chip enable still low, the state becomes standby and `data_hold_o` stays 1.
- R7: `low_pwr_o` is 1 exactly when the state is standby and `eng_busy_i` is 0.
- R8: While `sup_low_i` is 1, the state is locked-out and `pe_inhibit_o` is 1. When the flag clears, the state goes to active if chip enable is low, and to standby otherwise.
- R9: A 1-to-0 transition of `sup_rst_i` puts the state in power-on-reset and raises `cold_rst_o` for exactly one clock. Reset release behaves the same way. `pe_inhibit_o` is 1 in power-on-reset.
- R10: A falling edge of chip enable while in standby moves the state to active on the next clock.
- R11: `state_o` encodes power-on-reset=0, locked-out=1, standby=2, active=3, sleep=4. The block resets into power-on-reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Host address bus |
| eng_busy_i | input | 1 | Embedded engine busy |
| sup_low_i | input | 1 | Supply below lock-out level |
| sup_rst_i | input | 1 | Supply below reset level |
| state_o | output | 3 | Interface power state |
| drive_en_o | output | 1 | Data output drive enable |
| data_hold_o | output | 1 | Read data latched and held |
| pe_inhibit_o | output | 1 | Program/erase inhibit |
| cold_rst_o | output | 1 | Cold-reset request, one clock |
| low_pwr_o | output | 1 | Interface standby and engine idle |
| ready_o | output | 1 | Ready/busy status, from the engine |

## Verification
`state_o`, `data_hold_o` and `cold_rst_o` are registered. They change at the first clock edge that samples a stimulus. Sleep arrives `SLEEP_CYC` edges after the last address change, and standby arrives `STBY_CYC` edges after sleep entry. `drive_en_o`, `pe_inhibit_o`, `low_pwr_o` and `ready_o` combine the current state with live inputs, so they follow an input in the same cycle. The bench applies inputs on the falling edge, lets the exact number of rising edges each result needs go by, and samples on the next falling edge. Every vector states that edge count.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_LOCK  = 3'd1,
    ST_STBY  = 3'd2,
    ST_ACT   = 3'd3,
    ST_SLEEP = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/fpc_supply_mon.sv
module fpc_supply_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_low_i,
  input  logic sup_rst_i,
  output logic lock_o,
  output logic por_req_o,
  output logic cold_o
);
  logic rst_seen_q;
  logic cold_q;

  // reset value 1: leaving reset counts as a supply recovery
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_seen_q <= 1'b1;
      cold_q     <= 1'b0;
    end else begin
      rst_seen_q <= sup_rst_i;
      cold_q     <= por_req_o;
    end
  end

  assign por_req_o = rst_seen_q & ~sup_rst_i;
  assign lock_o    = sup_low_i | sup_rst_i;
  assign cold_o    = cold_q;

  AST_COLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_o |=> !cold_o); // R9
endmodule

// File: rtl/fpc_addr_watch.sv
module fpc_addr_watch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              chg_o,
  output logic              sel_fall_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ce_q   <= 1'b1;
    end else begin
      addr_q <= addr_i;
      ce_q   <= ce_ni;
    end
  end

  assign chg_o      = (addr_i != addr_q);
  assign sel_fall_o = ce_q & ~ce_ni;
endmodule

// File: rtl/fpc_state_fsm.sv
module fpc_state_fsm
  import flash_pwr_pkg::*;
#(
  parameter int SLEEP_CYC = 8,
  parameter int STBY_CYC  = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       chg_i,
  input  logic       sel_fall_i,
  input  logic       lock_i,
  input  logic       por_req_i,
  output pwr_state_e state_o,
  output logic       deep_o
);
  localparam int MAXC = (SLEEP_CYC > STBY_CYC) ? SLEEP_CYC : STBY_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SLP_LAST = CW'(SLEEP_CYC - 1);
  localparam logic [CW-1:0] SBY_LAST = CW'(STBY_CYC - 1);

  pwr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          deep_q, deep_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    deep_d  = 1'b0;
    if (por_req_i) begin
      state_d = ST_POR;
      cnt_d   = '0;
    end else if (lock_i) begin
      state_d = ST_LOCK;
      cnt_d   = '0;
    end else if (ce_ni) begin
      state_d = ST_STBY;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_POR, ST_LOCK: begin
          state_d = ST_ACT;
          cnt_d   = '0;
        end
        ST_STBY: begin
          if (sel_fall_i || chg_i) begin
            state_d = ST_ACT;
            cnt_d   = '0;
          end else begin
            deep_d = deep_q;
          end
        end
        ST_ACT: begin
          if (chg_i) begin
            cnt_d = '0;
          end else if (cnt_q == SLP_LAST) begin
            state_d = ST_SLEEP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (chg_i) begin
            state_d = ST_ACT;
            cnt_d   = '0;
          end else if (cnt_q == SBY_LAST) begin
            state_d = ST_STBY;
            cnt_d   = '0;
            deep_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_POR;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      deep_q  <= deep_d;
    end
  end

  assign state_o = state_q;
  assign deep_o  = deep_q;

  AST_LOCK_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !por_req_i) |=> (state_q == ST_LOCK)); // R8
  AST_DESELECT_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !lock_i && !por_req_i) |=> (state_q == ST_STBY)); // R1
  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && chg_i && !ce_ni && !lock_i && !por_req_i)
      |=> (state_q == ST_ACT && cnt_q == '0)); // R5
  AST_SEL_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && sel_fall_i && !lock_i && !por_req_i)
      |=> (state_q == ST_ACT)); // R10
endmodule

// File: rtl/flash_if_pwr_ctrl.sv
module flash_if_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SLEEP_CYC = 8,
  parameter int STBY_CYC  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              eng_busy_i,
  input  logic              sup_low_i,
  input  logic              sup_rst_i,
  output logic [2:0]        state_o,
  output logic              drive_en_o,
  output logic              data_hold_o,
  output logic              pe_inhibit_o,
  output logic              cold_rst_o,
  output logic              low_pwr_o,
  output logic              ready_o
);
  logic       lock, por_req, cold, chg, sel_fall, deep;
  pwr_state_e st;
  logic       st_readable;

  fpc_supply_mon u_sup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sup_low_i (sup_low_i),
    .sup_rst_i (sup_rst_i),
    .lock_o    (lock),
    .por_req_o (por_req),
    .cold_o    (cold)
  );

  fpc_addr_watch #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .addr_i     (addr_i),
    .chg_o      (chg),
    .sel_fall_o (sel_fall)
  );

  fpc_state_fsm #(.SLEEP_CYC(SLEEP_CYC), .STBY_CYC(STBY_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .chg_i      (chg),
    .sel_fall_i (sel_fall),
    .lock_i     (lock),
    .por_req_i  (por_req),
    .state_o    (st),
    .deep_o     (deep)
  );

  assign st_readable  = (st == ST_ACT) || (st == ST_SLEEP) || (st == ST_STBY);
  assign state_o      = st;
  assign drive_en_o   = ~ce_ni & ~oe_ni & st_readable;
  assign data_hold_o  = (st == ST_SLEEP) | deep;
  assign pe_inhibit_o = lock | (st == ST_LOCK) | (st == ST_POR);
  assign cold_rst_o   = cold;
  assign low_pwr_o    = (st == ST_STBY) & ~eng_busy_i;
  assign ready_o      = ~eng_busy_i;

  AST_POR_ON_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sup_rst_i) |=> (cold_rst_o && st == ST_POR)); // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SLEEP) |-> data_hold_o); // R4
endmodule

// File: tb/sim_flash_if_pwr_ctrl.sv
module sim_flash_if_pwr_ctrl;
  localparam int AW = 8;
  localparam int NV = 19;

  typedef struct packed {
    logic       ce, oe, busy, lo, rs;
    logic [7:0] addr;
    logic [3:0] n;
    logic [2:0] st;
    logic       drv, hold, inh, lp, cold;
  } vec_t;

  // inputs: ce oe busy sup_low sup_rst addr edges | expected: state drive hold inhibit lowpwr cold
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h10,4'd1, 3'd3,1'b0,1'b0,1'b0,1'b0,1'b0}, // R10
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h10,4'd3, 3'd3,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h10,4'd1, 3'd4,1'b1,1'b1,1'b0,1'b0,1'b0}, // R3
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h10,4'd5, 3'd4,1'b0,1'b1,1'b0,1'b0,1'b0}, // R4
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h10,4'd1, 3'd2,1'b1,1'b1,1'b0,1'b1,1'b0}, // R6
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h10,4'd1, 3'd2,1'b1,1'b1,1'b0,1'b0,1'b0}, // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h22,4'd1, 3'd3,1'b1,1'b0,1'b0,1'b0,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h22,4'd4, 3'd4,1'b1,1'b1,1'b0,1'b0,1'b0}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h23,4'd1, 3'd3,1'b1,1'b0,1'b0,1'b0,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h23,4'd3, 3'd3,1'b1,1'b0,1'b0,1'b0,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h23,4'd1, 3'd4,1'b1,1'b1,1'b0,1'b0,1'b0}, // R5
    '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h55,4'd1, 3'd2,1'b0,1'b0,1'b0,1'b1,1'b0}, // R1
    '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h66,4'd3, 3'd2,1'b0,1'b0,1'b0,1'b1,1'b0}, // R1
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h66,4'd1, 3'd1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R8
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h66,4'd2, 3'd1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R8
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h66,4'd1, 3'd3,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8
    '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h66,4'd2, 3'd1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R9
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h66,4'd1, 3'd0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R9
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h66,4'd1, 3'd3,1'b1,1'b0,1'b0,1'b0,1'b0}  // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0, s_lo = 1'b0, s_rs = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0] state;
  logic drv, hold, inh, cold, lp, rdy;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_if_pwr_ctrl #(.ADDR_W(AW), .SLEEP_CYC(4), .STBY_CYC(6)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .addr_i(addr),
    .eng_busy_i(busy), .sup_low_i(s_lo), .sup_rst_i(s_rs),
    .state_o(state), .drive_en_o(drv), .data_hold_o(hold), .pe_inhibit_o(inh),
    .cold_rst_o(cold), .low_pwr_o(lp), .ready_o(rdy)
  );

  function automatic string req_of(int i);
    case (i)
      0: return "R10";
      1, 2, 7: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      6, 8, 9, 10: return "R5";
      11, 12: return "R1";
      13, 14, 15: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset state", int'(state), 0);
    chk("R11", "reset inhibit", int'(inh), 1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9", "cold after reset", int'(cold), 1);
    chk("R11", "por state", int'(state), 0);
    @(posedge clk); @(negedge clk);
    chk("R9", "cold one clock", int'(cold), 0);
    chk("R1", "standby after por", int'(state), 2);
    chk("R7", "low power idle", int'(lp), 1);

    for (int i = 0; i < NV; i++) begin
      ce_n = TBL[i].ce; oe_n = TBL[i].oe; busy = TBL[i].busy;
      s_lo = TBL[i].lo; s_rs = TBL[i].rs; addr = TBL[i].addr;
      repeat (int'(TBL[i].n)) @(posedge clk);
      @(negedge clk);
      chk(req_of(i), $sformatf("vec %0d state", i), int'(state), int'(TBL[i].st));
      chk(req_of(i), $sformatf("vec %0d drive", i), int'(drv), int'(TBL[i].drv));
      chk(req_of(i), $sformatf("vec %0d hold", i), int'(hold), int'(TBL[i].hold));
      chk(req_of(i), $sformatf("vec %0d inhibit", i), int'(inh), int'(TBL[i].inh));
      chk(req_of(i), $sformatf("vec %0d lowpwr", i), int'(lp), int'(TBL[i].lp));
      chk(req_of(i), $sformatf("vec %0d cold", i), int'(cold), int'(TBL[i].cold));
      chk("R2", $sformatf("vec %0d ready", i), int'(rdy), int'(!TBL[i].busy));
    end

    // R2: ready follows busy in the same cycle, mid-cycle
    busy = 1'b1; #1;
    chk("R2", "ready busy", int'(rdy), 0);
    busy = 1'b0; #1;
    chk("R2", "ready idle", int'(rdy), 1);

    // R1: drive off at once when deselected, before any clock edge
    @(negedge clk); ce_n = 1'b1; #1;
    chk("R1", "drive off deselect", int'(drv), 0);
    @(posedge clk); @(negedge clk);
    chk("R1", "standby deselect", int'(state), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule